// File: doc/BRIEF.md
# Fractional-N Synthesizer Word Calculator

This block turns a requested tuning frequency and the reference clock frequency, both in Hz, into the five bytes that program a fractional-N synthesizer. It first picks a band from a fixed ordered list of upper frequency limits. The band sets the output divider and two band bits. The block then forms the VCO frequency and picks the VCO range bit. It also chooses a reference divider of 1, 2 or 4, so that the integer divider stays above its floor. Last, it works out the integer divider N and a 20-bit fraction K.

A request is taken on a one-cycle `start` pulse. A restoring shift-subtract divider then runs one quotient bit per cycle. It divides the VCO frequency, extended by 20 fraction bits, by the phase-detector step 2·Fref/R. The upper bits of the single quotient are N and the lower 20 bits are K. A one-cycle `done` pulse ends the request. The block also reports the selected band index and whether the band changed since the last accepted request. Requests it cannot encode raise `err` and leave every output byte untouched.

Top module: `fracn_word_calc`

## Requirements
- R1: The band is the first entry whose limit is at or above the frequency. The limits are 400, 538, 794 and 925 MHz and `LIM_TOP` (default 2 GHz). The bands use output dividers 12, 4, 4, 4 and 2. Bits [7:6] of `cfg_byte` are 2'b10 for band 0, 2'b00 for bands 1 to 3 and 2'b01 for band 4.
- R2: The VCO frequency is the requested frequency times the output divider. Bits [3:0] of `cfg_byte` are 4'h6 when it is below 2.6 GHz and 4'hE otherwise. Bits [5:4] of `cfg_byte` are zero.
- R3: R is 1 when VCO ≥ 152·Fref, 2 when VCO ≥ 76·Fref, and 4 otherwise. `rk_byte[5:4]` carries the R code: 0, 1 or 2. `rk_byte[7:6]` is zero.
- R4: With D = floor(2·Fref/R), N = floor(VCO/D) and K = floor((VCO mod D)·2^20/D). `n_byte` is N. `rk_byte[3:0]` is K[19:16], `kmid_byte` is K[15:8] and `klo_byte` is K[7:0].
- R5: `band_idx` holds the band of the last accepted request. Reset sets it to 0. `band_changed` is 1 exactly when the accepted band differs from the previously stored one.
- R6: A request is rejected when the frequency is above `LIM_TOP`, when D is zero (including Fref = 0), or when N exceeds 255. On rejection `err` is set, and the bytes, `band_idx` and `band_changed` (forced to 0) keep their values. `err` is cleared by the next accepted request.
- R7: `done` is high for one cycle. For a request that reaches the divider, it rises DVW+1 cycles after the edge that samples `start`, where DVW = FW+24 (56 by default). A request rejected before dividing finishes after one cycle. `busy` is high from the accepting edge until `done`.
- R8: `start` is ignored while `busy` is high. Such a pulse causes no extra `done` and does not change the result.
- R9: After reset all output bytes, `band_idx`, `band_changed`, `err`, `busy` and `done` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled when idle |
| freq_hz | input | FW | Requested tuning frequency in Hz |
| fref_hz | input | FW | Reference clock frequency in Hz |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request rejected |
| cfg_byte | output | 8 | Band bits and VCO range bits |
| rk_byte | output | 8 | R code and K[19:16] |
| kmid_byte | output | 8 | K[15:8] |
| klo_byte | output | 8 | K[7:0] |
| n_byte | output | 8 | Integer divider N |
| band_idx | output | 3 | Band of the last accepted request |
| band_changed | output | 1 | Band differs from the previous one |

## Verification
Some properties are checked on every cycle:
- `done` is a single-cycle pulse that coincides with the return to idle.
- `busy` never outlasts the divider window.
- The outputs stay frozen while busy and on a rejection.
- The R code is never 3, and the VCO range nibble is always 6 or E after an accepted request.
- `band_changed` agrees with the step in `band_idx`.

The bench alone shows the rest. It checks the arithmetic values of N and K and the band boundaries at exactly 400 and 925 MHz. It covers the three reference-divider choices, the overflow rejection at low reference frequencies, and that a second `start` during a run has no effect.

// File: rtl/fracn_word_calc.sv
module fracn_word_calc #(
  parameter int FW = 32,
  parameter int PRE = 2,
  parameter int NMIN = 76,
  parameter logic [31:0] LIM0 = 32'd400000000,
  parameter logic [31:0] LIM1 = 32'd538000000,
  parameter logic [31:0] LIM2 = 32'd794000000,
  parameter logic [31:0] LIM3 = 32'd925000000,
  parameter logic [31:0] LIM_TOP = 32'd2000000000,
  parameter longint unsigned VCO_SPLIT = 64'd2600000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] freq_hz,
  input  logic [FW-1:0] fref_hz,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [7:0]    cfg_byte,
  output logic [7:0]    rk_byte,
  output logic [7:0]    kmid_byte,
  output logic [7:0]    klo_byte,
  output logic [7:0]    n_byte,
  output logic [2:0]    band_idx,
  output logic          band_changed
);
  localparam int FRAC = 20;
  localparam int VW   = FW + 4;
  localparam int DVW  = VW + FRAC;
  localparam int DW   = FW + $clog2(PRE) + 1;
  localparam int TW   = FW + $clog2(PRE * NMIN) + 1;
  localparam int CW   = $clog2(DVW + 1);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_FIN} st_t;
  st_t st;

  logic [2:0]    sel_c, sel_r;
  logic [3:0]    div_c;
  logic [1:0]    bb_c, rsel_c, rsel_r;
  logic          hit_c, bad_c, bad_r;
  logic [VW-1:0] vco_c;
  logic [TW-1:0] thr_c;
  logic [DW-1:0] d_c, d_r, rem, rem_nx;
  logic [7:0]    cfg_c, cfg_r;
  logic [DVW-1:0] dvd, quo;
  logic [CW-1:0] cnt;
  logic [DW:0]   trial;
  logic          ge, ovf;

  always_comb begin
    hit_c = 1'b1;
    sel_c = 3'd4;
    div_c = 4'd2;
    bb_c  = 2'b01;
    if (32'(freq_hz) <= LIM0) begin
      sel_c = 3'd0; div_c = 4'd12; bb_c = 2'b10;
    end else if (32'(freq_hz) <= LIM1) begin
      sel_c = 3'd1; div_c = 4'd4; bb_c = 2'b00;
    end else if (32'(freq_hz) <= LIM2) begin
      sel_c = 3'd2; div_c = 4'd4; bb_c = 2'b00;
    end else if (32'(freq_hz) <= LIM3) begin
      sel_c = 3'd3; div_c = 4'd4; bb_c = 2'b00;
    end else if (32'(freq_hz) > LIM_TOP) begin
      hit_c = 1'b0;
    end
  end

  assign vco_c  = VW'(freq_hz) * VW'(div_c);
  assign cfg_c  = {bb_c, 6'b0} | ((vco_c < VW'(VCO_SPLIT)) ? 8'h06 : 8'h0E);
  assign thr_c  = TW'(PRE * NMIN) * TW'(fref_hz);
  assign rsel_c = (TW'(vco_c) >= thr_c) ? 2'd0 :
                  (TW'(vco_c) >= (thr_c >> 1)) ? 2'd1 : 2'd2;
  assign d_c    = (DW'(PRE) * DW'(fref_hz)) >> rsel_c;
  assign bad_c  = !hit_c || (d_c == '0);

  assign trial  = {rem, dvd[DVW-1]};
  assign ge     = trial >= {1'b0, d_r};
  assign rem_nx = ge ? DW'(trial - {1'b0, d_r}) : trial[DW-1:0];
  assign ovf    = |quo[DVW-1:FRAC+8];
  assign busy   = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sel_r <= '0; cfg_r <= '0; rsel_r <= '0; d_r <= '0; bad_r <= 1'b0;
      rem <= '0; dvd <= '0; quo <= '0; cnt <= '0;
      done <= 1'b0; err <= 1'b0; band_changed <= 1'b0; band_idx <= '0;
      cfg_byte <= '0; rk_byte <= '0; kmid_byte <= '0; klo_byte <= '0; n_byte <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          sel_r  <= sel_c;
          cfg_r  <= cfg_c;
          rsel_r <= rsel_c;
          d_r    <= d_c;
          bad_r  <= bad_c;
          rem    <= '0;
          dvd    <= {vco_c, {FRAC{1'b0}}};
          quo    <= '0;
          cnt    <= '0;
          st     <= bad_c ? S_FIN : S_DIV;
        end
        S_DIV: begin
          rem <= rem_nx;
          dvd <= dvd << 1;
          quo <= {quo[DVW-2:0], ge};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(DVW - 1)) st <= S_FIN;
        end
        S_FIN: begin
          done <= 1'b1;
          st   <= S_IDLE;
          if (bad_r || ovf) begin
            err <= 1'b1;
            band_changed <= 1'b0;
          end else begin
            err          <= 1'b0;
            cfg_byte     <= cfg_r;
            rk_byte      <= {2'b00, rsel_r, quo[FRAC-1:FRAC-4]};
            kmid_byte    <= quo[15:8];
            klo_byte     <= quo[7:0];
            n_byte       <= quo[FRAC+7:FRAC];
            band_changed <= (sel_r != band_idx);
            band_idx     <= sel_r;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fracn_word_calc_chk.sv
module fracn_word_calc_chk #(
  parameter int FW = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [7:0] cfg_byte,
  input logic [7:0] rk_byte,
  input logic [7:0] kmid_byte,
  input logic [7:0] klo_byte,
  input logic [7:0] n_byte,
  input logic [2:0] band_idx,
  input logic       band_changed
);
  localparam int BUSY_MAX = FW + 24 + 1;
  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else busy_run <= 0;
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rst_n) busy |-> busy_run < BUSY_MAX);
  p_hold_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> ($stable(n_byte) && $stable(klo_byte) && $stable(kmid_byte) &&
                       $stable(rk_byte) && $stable(cfg_byte) && $stable(band_idx) && !band_changed));
  p_band_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (band_changed == (band_idx != $past(band_idx))));
  p_rk_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rk_byte[7:6] == 2'b00) && (rk_byte[5:4] != 2'b11));
  p_cfg_vco_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> ((cfg_byte[3:0] == 4'h6) || (cfg_byte[3:0] == 4'hE)) && (cfg_byte[5:4] == 2'b00));
  p_stable_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($stable(n_byte) && $stable(rk_byte) && $stable(band_idx) && $stable(err)));
endmodule

bind fracn_word_calc fracn_word_calc_chk u_chk (.*);

// File: tb/fracn_word_calc_bench.sv
module fracn_word_calc_bench;
  localparam int DVW = 56;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] freq_hz = '0, fref_hz = '0;
  logic busy, done, err, band_changed;
  logic [7:0] cfg_byte, rk_byte, kmid_byte, klo_byte, n_byte;
  logic [2:0] band_idx;
  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] h_cfg = 0, h_rk = 0, h_km = 0, h_kl = 0, h_n = 0;
  logic [2:0] h_band = 0;

  fracn_word_calc u_fracn_word_calc (.*);

  always #2 clk = ~clk;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model(input longint unsigned f, input longint unsigned r, output bit bad,
                       output int band, output logic [7:0] cfg, output logic [7:0] rk,
                       output logic [7:0] km, output logic [7:0] kl, output logic [7:0] n,
                       output bit early);
    longint unsigned dv, vco, d, nn, k;
    int rc;
    logic [1:0] bb;
    bad = 0; early = 0;
    if (f <= 400000000) begin band = 0; dv = 12; bb = 2'b10; end
    else if (f <= 538000000) begin band = 1; dv = 4; bb = 2'b00; end
    else if (f <= 794000000) begin band = 2; dv = 4; bb = 2'b00; end
    else if (f <= 925000000) begin band = 3; dv = 4; bb = 2'b00; end
    else begin band = 4; dv = 2; bb = 2'b01; if (f > 2000000000) begin bad = 1; early = 1; end end
    vco = f * dv;
    if (vco >= 152 * r) rc = 0; else if (vco >= 76 * r) rc = 1; else rc = 2;
    d = (2 * r) >> rc;
    if (d == 0) begin bad = 1; early = 1; d = 1; end
    nn = vco / d;
    k = ((vco % d) << 20) / d;
    if (!early && nn > 255) bad = 1;
    cfg = {bb, 2'b00, (vco < 64'd2600000000) ? 4'h6 : 4'hE};
    rk = {2'b00, rc[1:0], k[19:16]};
    km = k[15:8]; kl = k[7:0]; n = nn[7:0];
  endtask

  task automatic run(input logic [31:0] f, input logic [31:0] r, input bit inject);
    bit bad, early;
    int band, lat, extra;
    logic [7:0] cfg, rk, km, kl, n;
    model(f, r, bad, band, cfg, rk, km, kl, n, early);
    @(negedge clk);
    freq_hz = f; fref_hz = r; start = 1'b1;
    lat = 0;
    while (1) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (lat == 1) start = 1'b0;
      if (inject && lat == 5) begin start = 1'b1; freq_hz = 32'd1500000000; fref_hz = 32'd16000000; end
      if (inject && lat == 6) start = 1'b0;
      if (done || lat > 300) break;
    end
    chk("R7 done latency", lat, early ? 2 : DVW + 2);
    chk("R6 err", err, bad);
    if (!bad) begin
      chk("R1 band bits", cfg_byte[7:6], cfg[7:6]);
      chk("R2 vco range", cfg_byte[5:0], cfg[5:0]);
      chk("R3 ref code", rk_byte[7:4], rk[7:4]);
      chk("R4 K high", rk_byte[3:0], rk[3:0]);
      chk("R4 K mid", kmid_byte, km);
      chk("R4 K low", klo_byte, kl);
      chk("R4 N", n_byte, n);
      chk("R5 band changed", band_changed, band != int'(h_band));
      chk("R5 band idx", band_idx, band);
      h_cfg = cfg; h_rk = rk; h_km = km; h_kl = kl; h_n = n; h_band = 3'(band);
    end else begin
      chk("R6 held cfg", cfg_byte, h_cfg);
      chk("R6 held rk", rk_byte, h_rk);
      chk("R6 held N", n_byte, h_n);
      chk("R6 held K", {kmid_byte, klo_byte}, {h_km, h_kl});
      chk("R6 held band", band_idx, h_band);
      chk("R6 flag clear", band_changed, 0);
    end
    if (inject) begin
      extra = 0;
      repeat (DVW + 6) begin @(negedge clk); if (done) extra++; end
      chk("R8 no extra done", extra, 0);
      chk("R8 result kept", n_byte, h_n);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R9 reset n", n_byte, 0);
    chk("R9 reset rk", {cfg_byte, rk_byte, kmid_byte, klo_byte}, 0);
    chk("R9 reset band", band_idx, 0);
    chk("R9 reset flags", {busy, done, err, band_changed}, 0);
    rst_n = 1'b1;
    run(32'd100000000, 32'd28800000, 0);
    run(32'd400000000, 32'd28800000, 0);
    run(32'd400000001, 32'd28800000, 0);
    run(32'd600000000, 32'd28800000, 0);
    run(32'd700000000, 32'd28800000, 0);
    run(32'd925000000, 32'd28800000, 0);
    run(32'd925000001, 32'd28800000, 0);
    run(32'd1575000000, 32'd24000000, 0);
    run(32'd30000000, 32'd28800000, 0);
    run(32'd2100000000, 32'd28800000, 0);
    run(32'd900000000, 32'd0, 0);
    run(32'd1000000000, 32'd1000000, 0);
    run(32'd600000000, 32'd16000000, 1);
    for (int i = 0; i < 60; i++) begin
      logic [31:0] f, r;
      int sel;
      sel = $urandom_range(0, 3);
      r = (sel == 0) ? 32'd28800000 : (sel == 1) ? 32'd16000000 : 32'($urandom_range(8000000, 40000000));
      f = ($urandom_range(0, 9) == 0) ? 32'($urandom_range(1990000000, 2100000000))
                                      : 32'($urandom_range(20000000, 2000000000));
      run(f, r, 0);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule